// File: doc/BRIEF.md
# Round-Robin Sample-and-Hold Refresh Sequencer

This block keeps a bank of analog hold capacitors charged from one shared converter. It steps through the channels in a fixed ring, one channel per cycle of a slow refresh clock. At each falling edge of that clock it takes the next channel's code from the register bank, presents that code to the converter and closes that channel's hold switch. The switch opens again at the following rising edge. The capacitor then keeps its value until the ring returns to the same channel.

The refresh clock comes from one of two sources. The first is an internal oscillator, built as a programmable divider of the system clock. The second is a shared clock pin driven from outside. While the internal source is in use, the block drives the oscillator onto the shared pin so that other devices can follow it. While the external source is in use, the pin is an input and passes through a two-flop synchronizer. The external clock is assumed to be slow and well-formed: at most 70 kHz, each pulse at least 4 µs wide, and a duty cycle above 30 %. Under these conditions every edge of the pin is seen exactly once.

Top module: `refresh_scan_top`

## Requirements
- R1: While reset is held (synchronous, active low), the block selects the internal source. All hold switches are open, `scan_idx` is 0, `dac_code` is 0, the internal oscillator level is high and its divider counter is cleared.
- R2: At a falling edge of the selected refresh clock, exactly one bit of `hold_en` is set: the bit of the channel being refreshed. It stays set through the low phase and clears at the next rising edge. At no time is more than one bit set.
- R3: Successive refreshes visit channels 0, 1, …, N_CH-1 and then wrap to 0. `scan_idx` always names the channel most recently refreshed.
- R4: At the falling edge that starts a refresh, `dac_code` takes the bank value of that channel (bits [ch*CODE_W +: CODE_W] of `chan_codes`). It holds that value for the whole low phase, even if the bank changes during it.
- R5: A value written to channel k is presented at k's next refresh. This takes between 1 and N_CH refresh cycles, depending on the position of the scan.
- R6: `src_sel` = 0 selects the internal oscillator and 1 selects the external pin. `osc_pin_oe` is 1 exactly while the internal source is in effect. The source in effect follows `src_sel` one clock later.
- R7: The internal oscillator toggles every `div_half` system clocks, with 0 treated as 1. `osc_pin_out` carries its level. In internal mode, `hold_en` changes on the same clock edge at which `osc_pin_out` falls or rises.
- R8: In external mode, a level change on `ext_clk_in` takes effect on `hold_en` at the third system clock edge after the change.
- R9: When the source in effect changes, all switches open on that clock edge. The scan restarts at channel 0 on the next falling edge of the new source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_sel | input | 1 | Refresh clock source: 0 internal, 1 external pin |
| div_half | input | DIV_W | Internal oscillator half period in system clocks (0 acts as 1) |
| ext_clk_in | input | 1 | Level of the shared clock pin |
| osc_pin_out | output | 1 | Internal oscillator level driven to the shared pin |
| osc_pin_oe | output | 1 | Output enable of the shared pin (1 in internal mode) |
| chan_codes | input | N_CH*CODE_W | Channel register bank, channel c at [c*CODE_W +: CODE_W] |
| dac_code | output | CODE_W | Code presented to the shared converter |
| hold_en | output | N_CH | One-hot hold switch enables |
| scan_idx | output | IDX_W | Channel of the latest refresh |

## Verification
If the scan pointer were wrong, the wrong bit of `hold_en` would be set, or the wrong code would reach the converter. This shows on the first refresh after the fault, within one refresh period. A stuck pointer or a broken wrap shows no later than one full ring of N_CH refreshes. An error in the oscillator divider or in the synchronizer depth shifts the edges of `hold_en` by whole system clocks. Because the bench compares every output against its reference model on every clock, such an error is caught at the first refresh edge. A fault in source tracking shows on the clock after `src_sel` moves, as a wrong `osc_pin_oe` or a switch that should have opened but did not.

// File: rtl/refseq_pkg.sv
// Shared defaults and helpers for the refresh sequencer.
// Assumes channel indices fit in the width chosen by the caller.
package refseq_pkg;
    localparam int unsigned RS_N_CH   = 18;
    localparam int unsigned RS_CODE_W = 10;
    localparam int unsigned RS_DIV_W  = 16;

    // Ring increment: wraps from last to zero.
    function automatic int unsigned ring_next(input int unsigned idx, input int unsigned n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction
endpackage

// File: rtl/refseq_int_osc.sv
// Internal refresh oscillator: divides the system clock and toggles its level
// every div_half cycles (0 acts as 1). It reports the edge it is about to make
// as a one-cycle event, aligned with the register update of the level.
// Assumes div_half is quasi-static; a smaller value takes effect at once.
module refseq_int_osc #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_half,
    output logic             osc_lvl,
    output logic             fall_evt,
    output logic             rise_evt
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] limit;
    logic             tick;

    // Terminal count of the divider.
    always_comb begin
        limit = (div_half == '0) ? '0 : div_half - 1'b1;
        tick  = (cnt >= limit);
    end

    assign fall_evt = tick & osc_lvl;
    assign rise_evt = tick & ~osc_lvl;

    // Divider counter and oscillator level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            osc_lvl <= 1'b1;
        end else if (tick) begin
            cnt     <= '0;
            osc_lvl <= ~osc_lvl;
        end else begin
            cnt     <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/refseq_pin_sync.sv
// Two-flop synchronizer for the external refresh clock, followed by an edge
// detector. An edge event is asserted for one cycle, two clocks after the
// pin changes. Assumes pulses much wider than a system clock.
module refseq_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall_evt,
    output logic rise_evt
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Synchronizer chain plus history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise_evt = sync_q[STAGES-1] & ~last_q;
    assign fall_evt = ~sync_q[STAGES-1] & last_q;
endmodule

// File: rtl/refseq_scan_core.sv
// Scan core: tracks the source in effect, walks the channel ring on falling
// refresh edges, latches the converter code and drives the one-hot switches.
// A change of source opens every switch and rewinds the ring to channel 0.
// Assumes at most one refresh edge event per cycle from each source.
module refseq_scan_core #(
    parameter int unsigned N_CH   = 18,
    parameter int unsigned CODE_W = 10,
    parameter int unsigned IDX_W  = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   src_sel,
    input  logic                   int_fall,
    input  logic                   int_rise,
    input  logic                   ext_fall,
    input  logic                   ext_rise,
    input  logic [N_CH*CODE_W-1:0] chan_codes,
    output logic                   src_q,
    output logic [N_CH-1:0]        hold_en,
    output logic [CODE_W-1:0]      dac_code,
    output logic [IDX_W-1:0]       scan_idx
);
    import refseq_pkg::*;

    logic [IDX_W-1:0]  next_idx;
    logic [IDX_W-1:0]  next_inc;
    logic [N_CH-1:0]   next_onehot;
    logic [CODE_W-1:0] next_code;
    logic              fall_sel;
    logic              rise_sel;
    logic              src_chg;

    // Decode the pending channel into a switch vector.
    for (genvar g = 0; g < N_CH; g++) begin : g_dec
        assign next_onehot[g] = (next_idx == IDX_W'(g));
    end

    // Select the pending channel's code from the bank.
    always_comb begin
        next_code = '0;
        for (int c = 0; c < N_CH; c++) begin
            if (next_onehot[c]) next_code = chan_codes[c*CODE_W +: CODE_W];
        end
    end

    // Edge events of the source in effect, and the ring increment.
    always_comb begin
        src_chg  = (src_sel != src_q);
        fall_sel = src_q ? ext_fall : int_fall;
        rise_sel = src_q ? ext_rise : int_rise;
        next_inc = IDX_W'(ring_next(int'(next_idx), N_CH));
    end

    // Sequencer state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q    <= 1'b0;
            next_idx <= '0;
            scan_idx <= '0;
            hold_en  <= '0;
            dac_code <= '0;
        end else if (src_chg) begin
            src_q    <= src_sel;
            next_idx <= '0;
            hold_en  <= '0;
        end else if (fall_sel) begin
            scan_idx <= next_idx;
            hold_en  <= next_onehot;
            dac_code <= next_code;
            next_idx <= next_inc;
        end else if (rise_sel) begin
            hold_en  <= '0;
        end
    end
endmodule

// File: rtl/refresh_scan_top.sv
// Top of the refresh sequencer: internal oscillator, pin synchronizer and
// scan core. The shared clock pin is driven by the oscillator while the
// internal source is in effect and treated as an input otherwise.
module refresh_scan_top #(
    parameter int unsigned N_CH   = refseq_pkg::RS_N_CH,
    parameter int unsigned CODE_W = refseq_pkg::RS_CODE_W,
    parameter int unsigned DIV_W  = refseq_pkg::RS_DIV_W,
    localparam int unsigned IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   src_sel,
    input  logic [DIV_W-1:0]       div_half,
    input  logic                   ext_clk_in,
    output logic                   osc_pin_out,
    output logic                   osc_pin_oe,
    input  logic [N_CH*CODE_W-1:0] chan_codes,
    output logic [CODE_W-1:0]      dac_code,
    output logic [N_CH-1:0]        hold_en,
    output logic [IDX_W-1:0]       scan_idx
);
    logic int_fall, int_rise, ext_fall, ext_rise, osc_lvl, src_q;

    refseq_int_osc #(.DIV_W(DIV_W)) osc_i (
        .clk(clk), .rst_n(rst_n), .div_half(div_half),
        .osc_lvl(osc_lvl), .fall_evt(int_fall), .rise_evt(int_rise)
    );

    refseq_pin_sync #(.STAGES(2)) sync_i (
        .clk(clk), .rst_n(rst_n), .pin(ext_clk_in),
        .fall_evt(ext_fall), .rise_evt(ext_rise)
    );

    refseq_scan_core #(.N_CH(N_CH), .CODE_W(CODE_W), .IDX_W(IDX_W)) core_i (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel),
        .int_fall(int_fall), .int_rise(int_rise),
        .ext_fall(ext_fall), .ext_rise(ext_rise),
        .chan_codes(chan_codes), .src_q(src_q),
        .hold_en(hold_en), .dac_code(dac_code), .scan_idx(scan_idx)
    );

    // Pin drive follows the source in effect.
    assign osc_pin_out = osc_lvl;
    assign osc_pin_oe  = ~src_q;
endmodule

// File: rtl/refresh_scan_chk.sv
// Property checker for refresh_scan_top, attached by bind below.
module refresh_scan_chk #(
    parameter int unsigned N_CH  = 18,
    parameter int unsigned IDX_W = 5,
    parameter int unsigned CODE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              src_sel,
    input logic              osc_pin_oe,
    input logic [N_CH-1:0]   hold_en,
    input logic [IDX_W-1:0]  scan_idx,
    input logic [CODE_W-1:0] dac_code
);
    logic seen_rst;

    // Marks that at least one reset cycle has passed.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_rst <= 1'b1;
    end

    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n || seen_rst !== 1'b1)
        $onehot0(hold_en));

    a_r2_idx_match: assert property (@(posedge clk) disable iff (!rst_n || seen_rst !== 1'b1)
        (hold_en != '0) |-> hold_en[scan_idx]);

    a_r3_ring_step: assert property (@(posedge clk) disable iff (!rst_n || seen_rst !== 1'b1)
        ($past(rst_n) && scan_idx != $past(scan_idx))
            |-> (scan_idx == '0 || scan_idx == $past(scan_idx) + 1'b1));

    a_r4_code_held: assert property (@(posedge clk) disable iff (!rst_n || seen_rst !== 1'b1)
        ($past(rst_n) && hold_en != '0 && hold_en == $past(hold_en)) |-> $stable(dac_code));

    a_r6_pin_dir: assert property (@(posedge clk) disable iff (!rst_n || seen_rst !== 1'b1)
        ($past(rst_n) && src_sel == $past(src_sel)) |-> (osc_pin_oe == !src_sel));

    a_r9_open_on_change: assert property (@(posedge clk) disable iff (!rst_n || seen_rst !== 1'b1)
        ($past(rst_n) && osc_pin_oe != $past(osc_pin_oe)) |-> (hold_en == '0));
endmodule

bind refresh_scan_top refresh_scan_chk #(.N_CH(N_CH), .IDX_W(IDX_W), .CODE_W(CODE_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .osc_pin_oe(osc_pin_oe),
    .hold_en(hold_en), .scan_idx(scan_idx), .dac_code(dac_code)
);

// File: tb/refresh_scan_top_tb_top.sv
module refresh_scan_top_tb_top;
    localparam int NCH = 18;
    localparam int CW  = 10;
    localparam int DW  = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            src_sel = 1'b0;
    logic [DW-1:0]   div_half = 16'd3;
    logic            ext_clk_in = 1'b0;
    logic [NCH*CW-1:0] chan_codes = '0;
    logic            osc_pin_out, osc_pin_oe;
    logic [CW-1:0]   dac_code;
    logic [NCH-1:0]  hold_en;
    logic [4:0]      scan_idx;

    int n_chk = 0;
    int n_bad = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    refresh_scan_top dut_i (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .div_half(div_half),
        .ext_clk_in(ext_clk_in), .osc_pin_out(osc_pin_out), .osc_pin_oe(osc_pin_oe),
        .chan_codes(chan_codes), .dac_code(dac_code), .hold_en(hold_en), .scan_idx(scan_idx)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on each rising clock.
    int m_cnt, m_osc, m_s1, m_s2, m_s3, m_src, m_next, m_cur, m_code;
    logic [NCH-1:0] m_hold;
    always @(posedge clk) begin
        int half;
        bit i_f, i_r, e_f, e_r, f, r;
        if (!rst_n) begin
            m_cnt = 0; m_osc = 1; m_s1 = 0; m_s2 = 0; m_s3 = 0;
            m_src = 0; m_next = 0; m_cur = 0; m_code = 0; m_hold = '0;
        end else begin
            half = (div_half == 0) ? 1 : int'(div_half);
            i_f = 0; i_r = 0;
            if (m_cnt >= half - 1) begin
                i_f = (m_osc == 1); i_r = (m_osc == 0);
                m_osc = 1 - m_osc; m_cnt = 0;
            end else m_cnt++;
            e_f = (m_s2 == 0 && m_s3 == 1);
            e_r = (m_s2 == 1 && m_s3 == 0);
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(ext_clk_in);
            if (int'(src_sel) != m_src) begin
                m_src = int'(src_sel); m_hold = '0; m_next = 0;
            end else begin
                f = m_src ? e_f : i_f;
                r = m_src ? e_r : i_r;
                if (f) begin
                    m_cur = m_next; m_hold = '0; m_hold[m_next] = 1'b1;
                    m_code = int'(chan_codes[m_next*CW +: CW]);
                    m_next = (m_next + 1) % NCH;
                end else if (r) m_hold = '0;
            end
        end
    end

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (cmp_en) begin
            chk(hold_en === m_hold, "R2", "hold_en vs model", hold_en, m_hold);
            chk(scan_idx === 5'(m_cur), "R3", "scan_idx vs model", scan_idx, m_cur);
            chk(dac_code === CW'(m_code), "R4", "dac_code vs model", dac_code, m_code);
            chk(osc_pin_out === 1'(m_osc), "R7", "osc_pin_out vs model", osc_pin_out, m_osc);
            chk(osc_pin_oe === 1'(1 - m_src), "R6", "osc_pin_oe vs model", osc_pin_oe, 1 - m_src);
        end
    end

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    task automatic set_code(input int ch, input int val);
        chan_codes[ch*CW +: CW] = CW'(val);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ext_cycles(input int n, input int hi, input int lo);
        for (int i = 0; i < n; i++) begin
            ext_clk_in = 1'b1; tick(hi);
            ext_clk_in = 1'b0; tick(lo);
        end
    endtask

    // Wait for a new refresh (hold_en goes from zero to non-zero).
    task automatic wait_close(output int ch);
        logic [NCH-1:0] prev;
        prev = hold_en;
        forever begin
            tick(1);
            if (prev == '0 && hold_en != '0) break;
            prev = hold_en;
        end
        ch = int'(scan_idx);
    endtask

    initial begin
        int ch, prev_ch, cnt;
        logic [CW-1:0] held;
        for (int c = 0; c < NCH; c++) set_code(c, 37 * c + 5);
        @(negedge clk); @(negedge clk);
        // R1: reset state.
        chk(hold_en == '0, "R1", "hold_en in reset", hold_en, 0);
        chk(scan_idx == 0, "R1", "scan_idx in reset", scan_idx, 0);
        chk(dac_code == 0, "R1", "dac_code in reset", dac_code, 0);
        chk(osc_pin_oe == 1'b1, "R1", "internal mode in reset", osc_pin_oe, 1);
        cmp_en = 1'b1;
        tick(2);
        rst_n = 1'b1;

        // R3: ring order over two full turns.
        wait_close(prev_ch);
        chk(prev_ch == 0, "R3", "first channel after reset", prev_ch, 0);
        for (int i = 0; i < 2 * NCH; i++) begin
            wait_close(ch);
            chk(ch == (prev_ch + 1) % NCH, "R3", "ring successor", ch, (prev_ch + 1) % NCH);
            prev_ch = ch;
        end

        // R4: a bank write during the low phase leaves dac_code alone.
        wait_close(ch);
        held = dac_code;
        set_code(ch, 10'h3C3);
        tick(1);
        chk(hold_en != '0 && dac_code == held, "R4", "code held in low phase", dac_code, held);

        // R5: a write to channel 7 appears within 1..NCH refreshes.
        tick(1);
        set_code(7, 10'h2A5);
        cnt = 0;
        do begin
            wait_close(ch);
            cnt++;
        end while (ch != 7 && cnt < 40);
        chk(dac_code == 10'h2A5, "R5", "new code reached channel 7", dac_code, 10'h2A5);
        chk(cnt >= 1 && cnt <= NCH, "R5", "refresh count to update", cnt, NCH);

        // R7: fastest divider (0 acts as 1), then a slow one.
        div_half = 16'd0;
        tick(60);
        div_half = 16'd5;
        tick(150);

        // R6 / R9: switch to the external pin; direction flips, switches open.
        ext_clk_in = 1'b1;
        tick(4);
        src_sel = 1'b1;
        tick(1);
        chk(osc_pin_oe == 1'b0, "R6", "pin is input in external mode", osc_pin_oe, 0);
        chk(hold_en == '0, "R9", "switches open on source change", hold_en, 0);
        tick(6);
        // R8: falling pin edge reaches hold_en at the third clock edge.
        ext_clk_in = 1'b0;
        tick(2);
        chk(hold_en == '0, "R8", "no refresh two edges after pin fall", hold_en, 0);
        tick(1);
        chk(hold_en == 18'h1, "R8", "refresh three edges after pin fall", hold_en, 1);
        chk(scan_idx == 0, "R9", "scan restarts at channel 0", scan_idx, 0);
        tick(4);
        ext_cycles(45, 6, 5);

        // R9: back to internal while a switch is closed.
        ext_clk_in = 1'b1; tick(6); ext_clk_in = 1'b0; tick(4);
        src_sel = 1'b0;
        tick(1);
        chk(hold_en == '0, "R9", "open on return to internal", hold_en, 0);
        chk(osc_pin_oe == 1'b1, "R6", "pin driven in internal mode", osc_pin_oe, 1);
        wait_close(ch);
        chk(ch == 0, "R9", "restart channel after return", ch, 0);
        tick(100);

        // R1 / R6: reset with external requested, then follow src_sel.
        rst_n = 1'b0; src_sel = 1'b1;
        tick(3);
        chk(osc_pin_oe == 1'b1, "R1", "reset forces internal mode", osc_pin_oe, 1);
        rst_n = 1'b1;
        tick(2);
        chk(osc_pin_oe == 1'b0, "R6", "external after reset release", osc_pin_oe, 0);
        ext_cycles(25, 5, 7);
        done = 1'b1;
        report();
    end
endmodule